// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a register-mapped SPI master. A host writes words into a 64-entry transmit queue. The block shifts each word out on MOSI, most significant bit first, and at the same time it collects the word that arrives on MISO into a 64-entry receive queue. The host programs the word length, a two-stage clock divider, the clock polarity, the clock phase and the select polarity. The host can let exchanges run as soon as transmit data is present, or it can hold them until it writes an explicit start request.

Eight status flags describe the two queues and the transfer engine. The threshold flags compare the queue levels against programmable levels. The overflow and transfer-complete events are sticky and are cleared by writing 1. A single interrupt line is the OR of the enabled flags. Clearing the enable bit stops the engine and empties both queues. The configuration registers stay writable while the block is disabled.

Top module: `spi_fifo_master`

## Requirements
- R1: The registers sit at these byte offsets: 0x00 receive pop, 0x04 transmit push, 0x08 control, 0x0C configuration, 0x10 interrupt enable, 0x14 thresholds (transmit level in [5:0], receive level in [21:16]), 0x18 status, 0x1C period. Read data appears one clock after the read strobe. The control, configuration, interrupt-enable, threshold and period registers read back what was written.
- R2: The word length is N = control[24:20] + 1, from 1 to 32 bits. Each word goes out MSB first on MOSI. The N bits received on MISO are stored right-aligned, with the upper bits zero.
- R3: Each SCLK half period lasts (pre+1)·2^post clock cycles. Pre is control[15:12] and post is control[11:8]. The first SCLK edge comes one half period after select asserts.
- R4: Control[19:18] selects a channel c. The channel's phase is config bit c and its polarity is config bit 4+c. SCLK idles at the polarity level. With phase 0, MISO is sampled on the leading edge of each bit. With phase 1, it is sampled on the trailing edge.
- R5: The select output is driven to config bit 12+c while an exchange runs and to its inverse otherwise. It stays asserted across back-to-back words.
- R6: When control bit 3 is 1, an exchange starts as soon as the transmit queue holds data. When bit 3 is 0, the exchange waits for a control write with bit 2 set. Control bit 2 reads 1 while that request is pending and returns to 0 once the transmit queue has drained.
- R7: Status bit 0 is transmit empty. Bit 1 is set when the transmit level is below its threshold. Bit 2 is transmit full. Bit 3 is set when the receive queue is not empty. Bit 4 is set when the receive queue is not empty and its level is at or above its threshold. Bit 5 is receive full.
- R8: Status bit 7 (transfer complete) is set when a word finishes and the transmit queue is empty. Status bit 6 (overflow) is set when a finished word finds the receive queue full; that word is dropped. Both bits are cleared by writing 1. Reading the receive register while the queue is empty returns 0.
- R9: A write to the transmit register while the queue is full is ignored.
- R10: The irq output is the OR of (status AND interrupt enable), bit by bit.
- R11: Clearing control bit 0 stops any exchange, empties both queues and clears status bits 6 and 7. The other control and configuration fields keep their values. Transmit writes made while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss | output | 1 | Slave select |

## Verification
The main exchange is run against a bench slave that follows the SPI mode rules on its own. A table of words covers all four polarity/phase pairings, word lengths of 1, 8, 12, 16 and 32 bits, and several divider settings. A mismatch in MOSI bit order, in the sampling edge or in the masking of the word length shows up as a wrong captured or received word. A wrong divider shows up in the measured gap between select and the first SCLK edge. Directed runs cover the held start request, a three-word burst that must keep select low, a 65-word push into a 64-entry queue followed by one word into a full receive queue, and the threshold flags. They also cover a disable while data is queued, and a non-zero channel select with an active-high select line.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 64,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_ss
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] A_RX = AW'('h00), A_TX = AW'('h04), A_CTL = AW'('h08),
    A_CFG = AW'('h0C), A_IE = AW'('h10), A_THR = AW'('h14), A_ST = AW'('h18), A_PER = AW'('h1C);

  logic [31:0] ctrl_q, cfg_q, period_q;
  logic [7:0]  ie_q;
  logic [5:0]  txthr_q, rxthr_q;
  logic        xch_q, tc_q, ovf_q, busy, sclk_q;
  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [19:0] cnt;
  logic [6:0]  ev;
  logic [31:0] tx_sh, rx_sh;

  wire       en    = ctrl_q[0];
  wire [1:0] ch    = ctrl_q[19:18];
  wire [4:0] nbm1  = ctrl_q[24:20];
  wire       cpha  = cfg_q[int'(ch)];
  wire       cpol  = cfg_q[4 + int'(ch)];
  wire       sspol = cfg_q[12 + int'(ch)];
  wire [5:0] nbits = {1'b0, nbm1} + 6'd1;
  wire [6:0] last_ev = {nbits, 1'b0};
  wire [19:0] half_len = (20'(ctrl_q[15:12]) + 20'd1) << ctrl_q[11:8];

  wire tick     = busy && (cnt == half_len - 20'd1);
  wire word_end = tick && (ev == last_ev);
  wire may_run  = ctrl_q[3] || xch_q;
  wire go       = en && !busy && (tx_cnt != '0) && may_run;
  wire next_go  = word_end && (tx_cnt != '0) && may_run;
  wire tx_pop   = go || next_go;
  wire wr_tx    = bus_wr && bus_addr == A_TX && en && tx_cnt != FULL;
  wire rd_rx    = bus_rd && bus_addr == A_RX && rx_cnt != '0;
  wire rx_push  = word_end && rx_cnt != FULL;
  wire ovf_set  = word_end && rx_cnt == FULL;
  wire samp     = (ev[0] == cpha);
  wire drv      = !samp && ev != '0;

  logic [7:0] status;
  assign status = {tc_q, ovf_q, rx_cnt == FULL,
                   (rx_cnt != '0) && (int'(rx_cnt) >= int'(rxthr_q)),
                   rx_cnt != '0, tx_cnt == FULL,
                   int'(tx_cnt) < int'(txthr_q), tx_cnt == '0};

  assign irq      = |(status & ie_q);
  assign spi_sclk = busy ? sclk_q : cpol;
  assign spi_ss   = busy ? sspol : ~sspol;
  assign spi_mosi = busy && tx_sh[nbm1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; cfg_q <= '0; period_q <= '0; ie_q <= '0;
      txthr_q <= '0; rxthr_q <= '0; bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTL: ctrl_q <= {bus_wdata[31:3], 1'b0, bus_wdata[1:0]};
          A_CFG: cfg_q <= {4'd0, bus_wdata[27:0]};
          A_IE:  ie_q <= bus_wdata[7:0];
          A_THR: begin txthr_q <= bus_wdata[5:0]; rxthr_q <= bus_wdata[21:16]; end
          A_PER: period_q <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (bus_addr)
          A_RX:  bus_rdata <= (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
          A_CTL: bus_rdata <= {ctrl_q[31:3], xch_q, ctrl_q[1:0]};
          A_CFG: bus_rdata <= cfg_q;
          A_IE:  bus_rdata <= {24'd0, ie_q};
          A_THR: bus_rdata <= {10'd0, rxthr_q, 10'd0, txthr_q};
          A_ST:  bus_rdata <= {24'd0, status};
          A_PER: bus_rdata <= period_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tx) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; sclk_q <= 1'b0; cnt <= '0; ev <= '0; tx_sh <= '0; rx_sh <= '0;
      xch_q <= 1'b0; tc_q <= 1'b0; ovf_q <= 1'b0;
    end else if (!en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; sclk_q <= 1'b0; xch_q <= 1'b0; tc_q <= 1'b0; ovf_q <= 1'b0;
      if (bus_wr && bus_addr == A_CTL && bus_wdata[0] && bus_wdata[2]) xch_q <= 1'b1;
    end else begin
      if (wr_tx) tx_wp <= tx_wp + 1'b1;
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(wr_tx) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rd_rx) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rd_rx);

      if (bus_wr && bus_addr == A_CTL && bus_wdata[0] && bus_wdata[2]) xch_q <= 1'b1;
      else if (word_end && tx_cnt == '0) xch_q <= 1'b0;
      if (word_end && tx_cnt == '0) tc_q <= 1'b1;
      else if (bus_wr && bus_addr == A_ST && bus_wdata[7]) tc_q <= 1'b0;
      if (ovf_set) ovf_q <= 1'b1;
      else if (bus_wr && bus_addr == A_ST && bus_wdata[6]) ovf_q <= 1'b0;

      if (tx_pop) begin
        busy <= 1'b1; tx_sh <= tx_mem[tx_rp]; rx_sh <= '0;
        ev <= '0; cnt <= '0; sclk_q <= cpol;
      end else if (word_end) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          ev <= ev + 7'd1;
          sclk_q <= ~sclk_q;
          if (samp) rx_sh <= {rx_sh[30:0], spi_miso};
          if (drv) tx_sh <= {tx_sh[30:0], 1'b0};
        end else begin
          cnt <= cnt + 20'd1;
        end
      end
    end
  end

  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !busy); // R11
  AST_SCLK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en) |-> sclk_q == cpol); // R4
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R9
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL); // R8
  AST_TC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tc_q) |-> !busy); // R8
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(rx_cnt) == FULL); // R8
endmodule

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;
  localparam logic [4:0] RXD = 5'h00, TXD = 5'h04, CTL = 5'h08, CFG = 5'h0C,
                         IE = 5'h10, THR = 5'h14, STA = 5'h18, PER = 5'h1C;
  // {cpol, cpha, len-1[4:0], pre[3:0], post[3:0], pad} , tx word
  localparam logic [47:0] VEC [6] = '{
    {1'b0, 1'b0, 5'd7,  4'd0, 4'd0, 1'b0, 32'h0000_00A5},
    {1'b0, 1'b1, 5'd7,  4'd2, 4'd0, 1'b0, 32'h0000_003C},
    {1'b1, 1'b0, 5'd15, 4'd0, 4'd1, 1'b0, 32'h0000_BEEF},
    {1'b1, 1'b1, 5'd11, 4'd1, 4'd1, 1'b0, 32'h0000_05A3},
    {1'b0, 1'b0, 5'd31, 4'd0, 4'd0, 1'b0, 32'hDEAD_BEEF},
    {1'b1, 1'b1, 5'd0,  4'd3, 4'd2, 1'b0, 32'h0000_0001}};

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sclk, spi_mosi, spi_miso, spi_ss;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_fifo_master u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss(spi_ss));

  function automatic logic [31:0] slw(int k);
    return 32'h6B2D_91C4 ^ (32'(k) * 32'h0101_0177);
  endfunction
  function automatic logic [31:0] mk(int n);
    return 32'hFFFF_FFFF >> (32 - n);
  endfunction

  // bench slave, independent SPI mode model
  bit b_cpol = 0, b_cpha = 0, b_sspol = 0;
  int b_n = 8;
  logic [31:0] sl_sh = '0, cap_sh = '0, cap_last = '0;
  int sk = 0, sedge = 0, hp_cnt = 0, hp_meas = 0, ss_offs = 0;
  bit hp_done = 0, ss_d_act = 0, lead;
  logic sclk_d = 0;
  wire ss_act = (spi_ss == b_sspol);
  assign spi_miso = sl_sh[b_n-1];

  always @(negedge clk) begin
    if (ss_act && !ss_d_act) begin
      sl_sh = slw(sk); cap_sh = '0; sedge = 0; hp_cnt = 1; hp_done = 0;
    end else if (ss_act && spi_sclk != sclk_d) begin
      if (!hp_done) begin hp_meas = hp_cnt; hp_done = 1; end
      lead = (sclk_d == b_cpol);
      if (lead != b_cpha) cap_sh = {cap_sh[30:0], spi_mosi};
      else if (sedge != 0) sl_sh = sl_sh << 1;
      sedge++;
      if (sedge == 2 * b_n) begin
        cap_last = cap_sh; sk++; sl_sh = slw(sk); sedge = 0; cap_sh = '0;
      end
    end else if (ss_act && !hp_done) hp_cnt++;
    if (!ss_act && ss_d_act) ss_offs++;
    sclk_d = spi_sclk; ss_d_act = ss_act;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask
  task automatic wait_tc();
    logic [31:0] s;
    for (int t = 0; t < 5000; t++) begin
      rd(STA, s);
      if (s[7]) return;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, ctl, tx;
    logic [47:0] v;
    int ek = 0, so, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(STA, d); chk(d == 32'h01, "R7 reset status", d, 32'h01);
    chk(irq == 0, "R10 reset irq", 32'(irq), 0);
    chk(spi_ss == 1 && spi_sclk == 0, "R5 reset idle pins", {spi_ss, spi_sclk}, 32'b10);
    wr(PER, 32'h1234_5678); rd(PER, d); chk(d == 32'h1234_5678, "R1 period readback", d, 32'h1234_5678);
    wr(THR, 32'h0015_0009); rd(THR, d); chk(d == 32'h0015_0009, "R1 threshold readback", d, 32'h0015_0009);
    wr(THR, 0);

    foreach (VEC[i]) begin
      v = VEC[i];
      tx = v[31:0];
      b_cpol = v[47]; b_cpha = v[46]; b_n = int'(v[45:41]) + 1;
      wr(CFG, {27'd0, v[47], 3'd0, v[46]});
      ctl = (32'(v[45:41]) << 20) | (32'(v[40:37]) << 12) | (32'(v[36:33]) << 8) | 32'hF9;
      wr(CTL, ctl);
      wr(TXD, tx);
      wait_tc();
      rd(RXD, d);
      chk(d == (slw(ek) & mk(b_n)), "R2 R4 received word", d, slw(ek) & mk(b_n));
      chk(cap_last == (tx & mk(b_n)), "R2 R4 sent word", cap_last, tx & mk(b_n));
      chk(hp_meas == ((int'(v[40:37]) + 1) << v[36:33]), "R3 half period", hp_meas,
          (int'(v[40:37]) + 1) << v[36:33]);
      ek++;
      wr(STA, 32'h80);
    end

    // R6: held start
    b_cpol = 0; b_cpha = 0; b_n = 8;
    wr(CFG, 0);
    ctl = (32'd7 << 20) | 32'hF1;
    wr(CTL, ctl); wr(TXD, 32'h5E);
    repeat (20) @(negedge clk);
    rd(STA, d);
    chk(spi_ss == 1 && d[0] == 0, "R6 held without request", {spi_ss, d[0]}, 32'b10);
    wr(CTL, ctl | 32'h4); rd(CTL, d);
    chk(d[2] == 1, "R6 request pending", d, ctl | 32'h4);
    wait_tc(); rd(RXD, d);
    chk(d == (slw(ek) & 32'hFF), "R6 word after request", d, slw(ek) & 32'hFF); ek++;
    rd(CTL, d); chk(d == ctl, "R6 request cleared", d, ctl);
    wr(STA, 32'h80);

    // R5: back-to-back burst keeps select
    so = ss_offs;
    for (int i = 0; i < 3; i++) wr(TXD, 32'h10 + 32'(i));
    wr(CTL, ctl | 32'h4); wait_tc();
    chk(ss_offs - so == 1, "R5 select held across burst", ss_offs - so, 1);
    chk(cap_last == 32'h12, "R5 last burst word", cap_last, 32'h12);
    for (int i = 0; i < 3; i++) begin
      rd(RXD, d); chk(d == (slw(ek) & 32'hFF), "R5 burst rx", d, slw(ek) & 32'hFF); ek++;
    end
    // R10 interrupt from transfer complete
    wr(IE, 32'h80);
    chk(irq == 1, "R10 irq on complete", 32'(irq), 1);
    wr(STA, 32'h80);
    chk(irq == 0, "R10 irq after w1c", 32'(irq), 0);
    wr(IE, 0);

    // R7 thresholds
    wr(THR, (32'd2 << 16) | 32'd4);
    wr(TXD, 1); wr(TXD, 2); rd(STA, d);
    chk(d[1] == 1, "R7 tx below threshold", d, 32'h02);
    wr(TXD, 3); wr(TXD, 4); wr(TXD, 5); rd(STA, d);
    chk(d[1] == 0, "R7 tx at threshold", d, 0);
    wr(CTL, ctl | 32'h4); wait_tc(); rd(STA, d);
    chk(d[4:3] == 2'b11, "R7 rx level flags", d, 32'h18);
    for (int i = 0; i < 4; i++) rd(RXD, d);
    rd(STA, d); chk(d[4:3] == 2'b01, "R7 rx below threshold", d, 32'h08);
    rd(RXD, d); ek += 5;
    wr(THR, 0); wr(STA, 32'h80);

    // R9, R8 overflow and empty read
    for (int i = 0; i < 65; i++) wr(TXD, 32'h100 + 32'(i));
    rd(STA, d); chk(d[2] == 1, "R9 tx full", d, 32'h04);
    wr(CTL, ctl | 32'h4); wait_tc();
    chk(cap_last == 32'h3F, "R9 extra push ignored", cap_last, 32'h3F);
    rd(STA, d); chk(d[6:5] == 2'b01, "R7 rx full no overflow", d, 32'h20);
    wr(STA, 32'h80); wr(TXD, 32'h77); wr(CTL, ctl | 32'h4); wait_tc();
    rd(STA, d); chk(d[6] == 1, "R8 overflow set", d, 32'h40);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd(RXD, d); if (d != (slw(ek + i) & 32'hFF)) bad++;
    end
    chk(bad == 0, "R8 kept words intact", bad, 0);
    ek += 65;
    rd(RXD, d); chk(d == 0, "R8 empty read", d, 0);
    wr(STA, 32'h40); rd(STA, d); chk(d[6] == 0, "R8 overflow w1c", d, 0);

    // R11 disable
    wr(STA, 32'h80);
    wr(TXD, 32'hA1); wr(TXD, 32'hA2);
    wr(CTL, ctl & ~32'h1); rd(STA, d);
    chk(d == 32'h01, "R11 queues flushed", d, 32'h01);
    rd(CTL, d); chk(d == (ctl & ~32'h1), "R11 fields retained", d, ctl & ~32'h1);
    so = ss_offs;
    wr(TXD, 32'h99); wr(CTL, ctl | 32'h8);
    repeat (40) @(negedge clk); rd(STA, d);
    chk(d[0] == 1 && ss_offs == so, "R11 disabled push ignored", d, 32'h01);

    // R4 R5 channel select with active-high select
    b_sspol = 1; b_cpol = 1; b_cpha = 1;
    wr(CFG, (32'h1 << 13) | (32'h1 << 5) | 32'h2);
    wr(CTL, ctl | (32'h1 << 18) | 32'h8);
    repeat (2) @(negedge clk);
    chk(spi_ss == 0 && spi_sclk == 1, "R5 R4 channel idle levels", {spi_ss, spi_sclk}, 32'b01);
    wr(TXD, 32'hC6); wait_tc(); rd(RXD, d);
    chk(d == (slw(ek) & 32'hFF), "R4 channel rx", d, slw(ek) & 32'hFF);
    chk(cap_last == 32'hC6, "R4 channel tx", cap_last, 32'hC6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule